// File: doc/BRIEF.md
# 8-bit Arithmetic and Logic Unit with Flag Update Mask

This unit is the combinational core of a small microcontroller execute stage. Each cycle it receives two byte operands, a carry bit taken from the status register and a four-bit operation code. In the same cycle it returns the byte result, the next values of six status flags, and a mask that marks which of those flags the operation writes. The surrounding pipeline writes back only the masked flags. Every other flag keeps its previous value.

Twelve operations are provided: plain and carry-chained addition and subtraction, bitwise AND/OR/XOR, bitwise inversion, negation, increment, decrement and a load of all ones. Each operation has its own flag set. Increment and decrement leave the carry alone. Inversion always sets carry. The all-ones load touches no flag.

Top module: `alu8_core`

## Requirements
- R1: Operation codes: 0 add, 1 add with carry, 2 subtract, 3 subtract with carry, 4 AND, 5 OR, 6 XOR, 7 invert, 8 negate, 9 increment, 10 decrement, 11 all ones. The arithmetic result is the low byte of A+B, A+B+cin, A−B or A−B−cin. The carry input enters only through codes 1 and 3.
- R2: For codes 0, 1, 2, 3 and 8, the mask covers all six flags. C is the carry out of bit 7 for additions and the borrow out of bit 7 for subtractions and negation.
- R3: H is the carry out of bit 3 for additions and the borrow into bit 4 for subtractions and negation.
- R4: V is set when the result, read as a signed byte, differs from the exact signed result of the operation.
- R5: For codes 4, 5 and 6, the mask holds only Z, N, V and S. V is 0 and C is not written.
- R6: Code 7 returns 0xFF minus A. The mask holds Z, C, N, V and S, with C forced to 1 and V 0.
- R7: Code 8 returns 0x00 minus A. C is 1 exactly when A is non-zero, and V is 1 exactly when A is 0x80.
- R8: Codes 9 and 10 return A+1 and A−1. The mask holds Z, N, V and S, never C. V is set at 0x7F→0x80 and 0x80→0x7F.
- R9: Code 11 returns 0xFF and the mask is all zero.
- R10: Flag and mask bit positions are C=0, Z=1, N=2, V=3, S=4, H=5. Z means the result is zero, N is result bit 7, and S is N XOR V.
- R11: Every flag bit outside the mask is driven 0. Codes 12 to 15 return 0x00 with an all-zero mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opSel | input | 4 | Operation code (R1) |
| opA | input | 8 | First operand, the destination register |
| opB | input | 8 | Second operand, register or immediate |
| carryIn | input | 1 | Carry flag from the status register |
| result | output | 8 | Operation result |
| flagsNext | output | 6 | Next flag values, masked |
| flagMask | output | 6 | Flags written by this operation |

## Verification
The assertions assume the inputs are settled two-state values when they are sampled. They also assume the operation code has been held long enough for the combinational outputs to settle. The bench drives every input on the falling clock edge and reads the outputs a few nanoseconds later, so no check sees a half-changed input. Random operands and carry bits cover all sixteen codes. The reserved codes 12 to 15 are included, so the assertions that apply to those codes are exercised too.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int FLAG_W = 6;
  localparam int FLG_C = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_N = 2;
  localparam int FLG_V = 3;
  localparam int FLG_S = 4;
  localparam int FLG_H = 5;

  localparam logic [FLAG_W-1:0] MASK_ARITH = 6'b111111;
  localparam logic [FLAG_W-1:0] MASK_LOGIC = 6'b011110;
  localparam logic [FLAG_W-1:0] MASK_INV   = 6'b011111;
  localparam logic [FLAG_W-1:0] MASK_NONE  = 6'b000000;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBC = 4'd3,
    OP_AND = 4'd4, OP_OR  = 4'd5, OP_XOR = 4'd6, OP_INV = 4'd7,
    OP_NEG = 4'd8, OP_INC = 4'd9, OP_DEC = 4'd10, OP_ONES = 4'd11
  } aluOp_e;

  typedef enum logic [1:0] { Y_B, Y_A, Y_ONE, Y_ZERO } ySel_e;
  typedef enum logic [1:0] { CK_ZERO, CK_ONE, CK_FLAG } carryKind_e;
  typedef enum logic [2:0] { LG_AND, LG_OR, LG_XOR, LG_NOT, LG_ONES, LG_ZERO } logicOp_e;

  typedef struct packed {
    logic              xZero;
    ySel_e             ySel;
    logic              subtract;
    carryKind_e        carryKind;
    logic              useLogic;
    logicOp_e          logicOp;
    logic              forceCarry;
    logic              clearOvf;
    logic [FLAG_W-1:0] mask;
  } aluCtrl_t;
endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
(
  input  logic [3:0] opSel,
  output aluCtrl_t   ctrl
);
  always_comb begin
    ctrl            = '0;
    ctrl.ySel       = Y_B;
    ctrl.carryKind  = CK_ZERO;
    ctrl.logicOp    = LG_ZERO;
    ctrl.useLogic   = 1'b1;
    ctrl.mask       = MASK_NONE;
    case (opSel)
      OP_ADD: begin ctrl.useLogic = 1'b0; ctrl.mask = MASK_ARITH; end
      OP_ADC: begin ctrl.useLogic = 1'b0; ctrl.carryKind = CK_FLAG; ctrl.mask = MASK_ARITH; end
      OP_SUB: begin ctrl.useLogic = 1'b0; ctrl.subtract = 1'b1; ctrl.mask = MASK_ARITH; end
      OP_SBC: begin
        ctrl.useLogic = 1'b0; ctrl.subtract = 1'b1;
        ctrl.carryKind = CK_FLAG; ctrl.mask = MASK_ARITH;
      end
      OP_NEG: begin
        ctrl.useLogic = 1'b0; ctrl.subtract = 1'b1; ctrl.xZero = 1'b1;
        ctrl.ySel = Y_A; ctrl.mask = MASK_ARITH;
      end
      OP_INC: begin
        ctrl.useLogic = 1'b0; ctrl.ySel = Y_ZERO;
        ctrl.carryKind = CK_ONE; ctrl.mask = MASK_LOGIC;
      end
      OP_DEC: begin
        ctrl.useLogic = 1'b0; ctrl.subtract = 1'b1;
        ctrl.ySel = Y_ONE; ctrl.mask = MASK_LOGIC;
      end
      OP_AND: begin ctrl.logicOp = LG_AND; ctrl.clearOvf = 1'b1; ctrl.mask = MASK_LOGIC; end
      OP_OR:  begin ctrl.logicOp = LG_OR;  ctrl.clearOvf = 1'b1; ctrl.mask = MASK_LOGIC; end
      OP_XOR: begin ctrl.logicOp = LG_XOR; ctrl.clearOvf = 1'b1; ctrl.mask = MASK_LOGIC; end
      OP_INV: begin
        ctrl.logicOp = LG_NOT; ctrl.clearOvf = 1'b1;
        ctrl.forceCarry = 1'b1; ctrl.mask = MASK_INV;
      end
      OP_ONES: begin ctrl.logicOp = LG_ONES; end
      default: begin ctrl.logicOp = LG_ZERO; end
    endcase
  end
endmodule

// File: rtl/alu8_datapath.sv
module alu8_datapath
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  aluCtrl_t          ctrl,
  input  logic [W-1:0]      opA,
  input  logic [W-1:0]      opB,
  input  logic              carryIn,
  output logic [W-1:0]      result,
  output logic [FLAG_W-1:0] flagsNext
);
  localparam int HALF = 4;
  localparam int MSB  = W - 1;

  logic [W-1:0]      xOp, yOp, yEff, logicRes;
  logic              cinRaw, cinEff;
  logic [W:0]        sum;
  logic [HALF:0]     nib;
  logic              carryF, halfF, ovfF, negF, zeroF;
  logic [FLAG_W-1:0] rawFlags;

  always_comb begin
    xOp = ctrl.xZero ? '0 : opA;
    case (ctrl.ySel)
      Y_A:     yOp = opA;
      Y_ONE:   yOp = {{(W-1){1'b0}}, 1'b1};
      Y_ZERO:  yOp = '0;
      default: yOp = opB;
    endcase
    yEff = ctrl.subtract ? ~yOp : yOp;
    case (ctrl.carryKind)
      CK_ONE:  cinRaw = 1'b1;
      CK_FLAG: cinRaw = carryIn;
      default: cinRaw = 1'b0;
    endcase
    cinEff = cinRaw ^ ctrl.subtract;
    sum = {1'b0, xOp} + {1'b0, yEff} + {{W{1'b0}}, cinEff};
    nib = {1'b0, xOp[HALF-1:0]} + {1'b0, yEff[HALF-1:0]} + {{HALF{1'b0}}, cinEff};
  end

  always_comb begin
    case (ctrl.logicOp)
      LG_AND:  logicRes = opA & opB;
      LG_OR:   logicRes = opA | opB;
      LG_XOR:  logicRes = opA ^ opB;
      LG_NOT:  logicRes = ~opA;
      LG_ONES: logicRes = '1;
      default: logicRes = '0;
    endcase
  end

  always_comb begin
    result = ctrl.useLogic ? logicRes : sum[W-1:0];
    carryF = ctrl.forceCarry | (sum[W] ^ ctrl.subtract);
    halfF  = nib[HALF] ^ ctrl.subtract;
    ovfF   = ~ctrl.clearOvf & (xOp[MSB] == yEff[MSB]) & (result[MSB] != xOp[MSB]);
    negF   = result[MSB];
    zeroF  = (result == '0);
    rawFlags        = '0;
    rawFlags[FLG_C] = carryF;
    rawFlags[FLG_Z] = zeroF;
    rawFlags[FLG_N] = negF;
    rawFlags[FLG_V] = ovfF;
    rawFlags[FLG_S] = negF ^ ovfF;
    rawFlags[FLG_H] = halfF;
    flagsNext = rawFlags & ctrl.mask;
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic [3:0] opSel,
  input  logic [7:0] opA,
  input  logic [7:0] opB,
  input  logic       carryIn,
  output logic [7:0] result,
  output logic [5:0] flagsNext,
  output logic [5:0] flagMask
);
  aluCtrl_t ctrlStrb;

  alu8_ctrl ctrl_i (
    .opSel (opSel),
    .ctrl  (ctrlStrb)
  );

  alu8_datapath #(.W(8)) dp_i (
    .ctrl      (ctrlStrb),
    .opA       (opA),
    .opB       (opB),
    .carryIn   (carryIn),
    .result    (result),
    .flagsNext (flagsNext)
  );

  assign flagMask = ctrlStrb.mask;
endmodule

// File: rtl/alu8_chk.sv
module alu8_chk
  import alu8_pkg::*;
(
  input logic [3:0] opSel,
  input logic [7:0] opA,
  input logic [7:0] opB,
  input logic       carryIn,
  input logic [7:0] result,
  input logic [5:0] flagsNext,
  input logic [5:0] flagMask
);
  always_comb begin
    // R9
    ones_noflag_chk: assert (opSel != 4'd11 || (result == 8'hFF && flagMask == 6'd0));
    // R8
    incdec_carry_chk: assert (!(opSel == 4'd9 || opSel == 4'd10) || !flagMask[FLG_C]);
    // R6
    inv_carry_chk: assert (opSel != 4'd7 || (flagsNext[FLG_C] && !flagsNext[FLG_V] && result == ~opA));
    // R10
    sign_rel_chk: assert (!flagMask[FLG_S] || flagsNext[FLG_S] == (flagsNext[FLG_N] ^ flagsNext[FLG_V]));
    // R10
    zero_flag_chk: assert (!flagMask[FLG_Z] || flagsNext[FLG_Z] == (result == 8'd0));
    // R11
    unmasked_low_chk: assert ((flagsNext & ~flagMask) == 6'd0);
    // R5
    logic_noovf_chk: assert (!(opSel >= 4'd4 && opSel <= 4'd6) || (flagMask == MASK_LOGIC && !flagsNext[FLG_V]));
    // R1
    add_sum_chk: assert (opSel != 4'd0 || result == opA + opB);
  end
endmodule

bind alu8_core alu8_chk chk_i (
  .opSel     (opSel),
  .opA       (opA),
  .opB       (opB),
  .carryIn   (carryIn),
  .result    (result),
  .flagsNext (flagsNext),
  .flagMask  (flagMask)
);

// File: tb/alu8_core_tb_top.sv
module alu8_core_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] opSel = 4'd11;
  logic [7:0] opA = 8'd0, opB = 8'd0;
  logic       carryIn = 1'b0;
  logic [7:0] result;
  logic [5:0] flagsNext, flagMask;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  alu8_core dut_i (
    .opSel(opSel), .opA(opA), .opB(opB), .carryIn(carryIn),
    .result(result), .flagsNext(flagsNext), .flagMask(flagMask)
  );

  // {op, a, b, cin, result, flags, mask}; flag order H S V N Z C
  localparam logic [40:0] VEC [12] = '{
    {4'd0,  8'h7F, 8'h01, 1'b0, 8'h80, 6'h2C, 6'h3F},
    {4'd1,  8'hFF, 8'h00, 1'b1, 8'h00, 6'h23, 6'h3F},
    {4'd2,  8'h00, 8'h01, 1'b0, 8'hFF, 6'h35, 6'h3F},
    {4'd3,  8'h80, 8'h00, 1'b1, 8'h7F, 6'h38, 6'h3F},
    {4'd8,  8'h80, 8'h00, 1'b0, 8'h80, 6'h0D, 6'h3F},
    {4'd7,  8'h0F, 8'h00, 1'b0, 8'hF0, 6'h15, 6'h1F},
    {4'd9,  8'h7F, 8'h00, 1'b1, 8'h80, 6'h0C, 6'h1E},
    {4'd10, 8'h01, 8'h00, 1'b1, 8'h00, 6'h02, 6'h1E},
    {4'd4,  8'hF0, 8'h0F, 1'b1, 8'h00, 6'h02, 6'h1E},
    {4'd11, 8'h12, 8'h34, 1'b1, 8'hFF, 6'h00, 6'h00},
    {4'd6,  8'hAA, 8'h55, 1'b0, 8'hFF, 6'h14, 6'h1E},
    {4'd12, 8'h33, 8'h44, 1'b1, 8'h00, 6'h00, 6'h00}
  };

  function automatic string reqOf(int op);
    case (op)
      0, 1, 2, 3: return "R1 R2 R3 R4";
      4, 5, 6:    return "R5";
      7:          return "R6";
      8:          return "R7";
      9, 10:      return "R8";
      11:         return "R9";
      default:    return "R11";
    endcase
  endfunction

  function automatic int sx(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic void refModel(input int op, input int a, input int b, input int c,
                                   output int res, output int flg, output int msk);
    int full = 0, sfull = 0, h = 0;
    bit cf = 0, hf = 0, vf = 0, nf, zf, sf;
    int x = a, y = b, cc = 0;
    msk = 0;
    case (op)
      0, 1: begin
        cc = (op == 1) ? c : 0;
        full = x + y + cc; sfull = sx(x) + sx(y) + cc; h = (x & 15) + (y & 15) + cc;
        cf = full > 255; hf = h > 15; msk = 63;
      end
      2, 3, 8: begin
        if (op == 8) begin x = 0; y = a; end
        cc = (op == 3) ? c : 0;
        full = x - y - cc; sfull = sx(x) - sx(y) - cc; h = (x & 15) - (y & 15) - cc;
        cf = full < 0; hf = h < 0; msk = 63;
      end
      4: begin full = a & b; msk = 30; end
      5: begin full = a | b; msk = 30; end
      6: begin full = a ^ b; msk = 30; end
      7: begin full = 255 - a; cf = 1; msk = 31; end
      9: begin full = a + 1; sfull = sx(a) + 1; msk = 30; end
      10: begin full = a - 1; sfull = sx(a) - 1; msk = 30; end
      11: begin full = 255; msk = 0; end
      default: begin full = 0; msk = 0; end
    endcase
    if (op <= 3 || op >= 8 && op <= 10) vf = (sfull > 127) || (sfull < -128);
    res = full & 255;
    zf = (res == 0); nf = (res > 127); sf = nf ^ vf;
    flg = {26'd0, hf, sf, vf, nf, zf, cf} & msk;
  endfunction

  task automatic compare(string tag, int expR, int expF, int expM);
    checks++;
    if (result != expR[7:0] || flagsNext != expF[5:0] || flagMask != expM[5:0]) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h cin=%0d: got res=%h flg=%h msk=%h, exp res=%h flg=%h msk=%h",
               tag, opSel, opA, opB, carryIn, result, flagsNext, flagMask,
               expR[7:0], expF[5:0], expM[5:0]);
    end
  endtask

  task automatic apply(int op, int a, int b, int c);
    @(negedge clk);
    opSel = op[3:0]; opA = a[7:0]; opB = b[7:0]; carryIn = c[0];
    #2;
  endtask

  task automatic runRef(string tag, int op, int a, int b, int c);
    int r, f, m;
    apply(op, a, b, c);
    refModel(op, a, b, c, r, f, m);
    compare(tag, r, f, m);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    // R9: idle inputs during reset
    #2 compare("R9 reset idle", 8'hFF, 0, 0);
    rst = 1'b0;

    foreach (VEC[i]) begin
      apply(int'(VEC[i][40:37]), int'(VEC[i][36:29]), int'(VEC[i][28:21]), int'(VEC[i][20]));
      compare(reqOf(int'(VEC[i][40:37])), int'(VEC[i][19:12]), int'(VEC[i][11:6]), int'(VEC[i][5:0]));
    end

    for (int i = 0; i < 3000; i++) begin
      int op = $urandom_range(15);
      runRef({reqOf(op), " R10 random"}, op, $urandom_range(255), $urandom_range(255), $urandom_range(1));
    end

    // R7: negate of zero gives no borrow
    runRef("R7 neg zero", 8, 0, 0, 1);
    // R3: borrow into bit 4 only
    runRef("R3 sub half borrow", 2, 8'h10, 8'h01, 0);
    // R1: carry-in ignored on plain subtract, used on SBC
    runRef("R1 sub ignores cin", 2, 8'h05, 8'h05, 1);
    runRef("R1 sbc uses cin", 3, 8'h05, 8'h05, 1);
    // R8: decrement from 0x80 overflows, carry mask clear even with cin set
    runRef("R8 dec 0x80", 10, 8'h80, 0, 1);
    // R5: OR with carry in set leaves C out of mask
    runRef("R5 or cin", 5, 8'h80, 8'h01, 1);
    // R11: highest reserved code
    runRef("R11 reserved 15", 15, 8'hFF, 8'hFF, 1);
    // R4: positive plus positive overflow
    runRef("R4 add ovf", 0, 8'h40, 8'h40, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired (all requirements)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule